// File: doc/BRIEF.md
# Three-Channel Output Compare Unit

This block turns the count of one shared down-counting timer into three independent output waveforms. Each channel owns two compare latches. A match on the first latch drives the channel's output pin to one level and a match on the second drives it to the other. A per-channel level bit swaps which latch sets and which latch clears. Every match can raise a one-cycle interrupt pulse, and each latch has its own enable. The timer is a reloadable 16-bit down counter with a run input. It flags an underflow strobe in the cycle it sits at zero and reloads on the next edge.

Software programs compare values through a small register port. A pointer register picks one of the six latches. Two byte registers form a window onto that latch's 16-bit buffer, and the two halves may be written in either order. While the timer runs, the buffered values stay out of the active latches until software sets the channel's reload bit. The pair is then committed at the next underflow and the bit clears itself. While the timer is stopped, window writes go straight into the active latch, and enabling a channel's trigger sets its pin to the channel's idle level.

The register port is a plain write strobe with a combinational read mux. Every write is accepted in the cycle it is presented, so the port has no back-pressure and no ready signal.

Top module: `ocu_top`

## Requirements
- R1: While `tmr_run` is high the count decrements by one per cycle. From 0 it loads `tmr_reload` on the next edge. `tmr_uf` is high exactly in the cycles where the timer runs and the count is 0.
- R2: Register addresses are: 0 window low byte, 1 window high byte, 2 latch pointer (bits 2:0), 3 reload bits, 4 trigger enables, 5 level bits, 6 interrupt enables, and 7 output status. Pointer codes 0 to 5 select latches 00, 01, 10, 11, 20 and 21. Codes 6 and 7 select no latch, and the window then reads 0. Pointer bits above bit 2 read 0. The two window halves update independently, in either order.
- R3: While the timer runs, a window write changes only the buffer. The active latch keeps its old value until an underflow that finds the channel's reload bit set.
- R4: Writing 1 to bit c of address 3 sets channel c's reload bit, and writing 0 has no effect. At the next underflow both buffers of that channel are copied into its active latches and the bit reads 0 again.
- R5: While the timer is stopped, a window write also lands at once in the selected active latch.
- R6: Writing address 4 with bit c = 1 while the timer is stopped sets output c to channel c's level bit on the next edge.
- R7: With trigger enabled and level 0, a count equal to latch x0 drives output c high and a count equal to latch x1 drives it low. Level 1 reverses both actions. The pin changes one cycle after the count reaches the value.
- R8: With trigger disabled, matches leave the output unchanged but still raise enabled interrupts.
- R9: If both latches of a channel match in the same cycle, the x1 action wins.
- R10: `cmp_irq` bit 2c+k pulses for one cycle, one cycle after latch ck matches, only when bit 2c+k of address 6 is set.
- R11: A latch value above `tmr_reload` never matches, and the other latch of the channel still works.
- R12: Address 7 reads back the three output levels. After reset all registers, the count, the outputs and the interrupts are 0.
- R13: While the timer is stopped the count holds and no latch matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, accepted every cycle |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| tmr_run | input | 1 | Timer run control |
| tmr_reload | input | 16 | Timer reload value |
| tmr_count | output | 16 | Current timer count |
| tmr_uf | output | 1 | Underflow strobe |
| cmp_out | output | 3 | Channel waveform outputs |
| cmp_irq | output | 6 | Per-latch compare interrupt pulses |

## Verification
On every cycle, the assertions check the following:
- the counter's decrement and reload steps, and its hold while stopped;
- that the active latches stay frozen between underflows while the timer runs;
- that the reload bits clear at underflow;
- that an output with its trigger disabled holds its level;
- the x1 priority;
- the match-to-interrupt relation.

Only the bench's scenarios can show the waveforms that emerge over whole timer periods: the polarity swap, a latch set beyond the reload value, a buffered update that waits for its reload bit, and the window and pointer readback. The bench compares every output against a cycle model on every cycle.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [2:0] {
    A_WLO = 3'd0,
    A_WHI = 3'd1,
    A_PTR = 3'd2,
    A_RLD = 3'd3,
    A_TEN = 3'd4,
    A_LVL = 3'd5,
    A_IEN = 3'd6,
    A_STS = 3'd7
  } ocu_addr_e;
endpackage

// File: rtl/ocu_timer.sv
module ocu_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] reload,
  output logic [TW-1:0] cnt,
  output logic          uf
);
  logic [TW-1:0] cnt_q;

  assign uf  = run && (cnt_q == '0);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
  end

  p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0) |=> cnt_q == TW'($past(cnt_q) - 1'b1));
  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> cnt_q == $past(reload));
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/ocu_regs.sv
module ocu_regs
  import ocu_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [TW/2-1:0] wr_data,
  input  logic [2:0]      rd_addr,
  output logic [TW/2-1:0] rd_data,
  input  logic            run,
  input  logic            uf,
  input  logic [NCH-1:0]  sts,
  output logic [TW-1:0]   lat_act [2*NCH],
  output logic [NCH-1:0]  te,
  output logic [NCH-1:0]  lvl,
  output logic [2*NCH-1:0] ie,
  output logic [NCH-1:0]  init
);
  localparam int DW = TW / 2;
  localparam int NL = 2 * NCH;
  localparam int PW = $clog2(NL);

  logic [TW-1:0]  buf_q [NL];
  logic [TW-1:0]  buf_nx [NL];
  logic [TW-1:0]  act_q [NL];
  logic [NL*TW-1:0] act_flat;
  logic [PW-1:0]  ptr_q;
  logic [NCH-1:0] rl_q;
  logic [NCH-1:0] te_q;
  logic [NCH-1:0] lvl_q;
  logic [NL-1:0]  ie_q;
  logic           ptr_ok;
  logic wr_lo, wr_hi, wr_ptr, wr_rl, wr_te, wr_lvl, wr_ie;

  assign wr_lo  = wr_en && (wr_addr == A_WLO);
  assign wr_hi  = wr_en && (wr_addr == A_WHI);
  assign wr_ptr = wr_en && (wr_addr == A_PTR);
  assign wr_rl  = wr_en && (wr_addr == A_RLD);
  assign wr_te  = wr_en && (wr_addr == A_TEN);
  assign wr_lvl = wr_en && (wr_addr == A_LVL);
  assign wr_ie  = wr_en && (wr_addr == A_IEN);
  assign ptr_ok = int'(ptr_q) < NL;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      buf_nx[i] = buf_q[i];
      if (ptr_ok && int'(ptr_q) == i) begin
        if (wr_lo) buf_nx[i][DW-1:0]  = wr_data;
        if (wr_hi) buf_nx[i][TW-1:DW] = wr_data;
      end
      act_flat[i*TW +: TW] = act_q[i];
      lat_act[i] = act_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin
        buf_q[i] <= '0;
        act_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NL; i++) begin
        buf_q[i] <= buf_nx[i];
        if (!run && (wr_lo || wr_hi) && ptr_ok && int'(ptr_q) == i)
          act_q[i] <= buf_nx[i];
        else if (uf && rl_q[i/2])
          act_q[i] <= buf_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      rl_q  <= '0;
      te_q  <= '0;
      lvl_q <= '0;
      ie_q  <= '0;
    end else begin
      if (wr_ptr) ptr_q <= wr_data[PW-1:0];
      rl_q <= (uf ? '0 : rl_q) | (wr_rl ? wr_data[NCH-1:0] : '0);
      if (wr_te)  te_q  <= wr_data[NCH-1:0];
      if (wr_lvl) lvl_q <= wr_data[NCH-1:0];
      if (wr_ie)  ie_q  <= wr_data[NL-1:0];
    end
  end

  assign te   = te_q;
  assign lvl  = lvl_q;
  assign ie   = ie_q;
  assign init = (wr_te && !run) ? wr_data[NCH-1:0] : '0;

  always_comb begin
    rd_data = '0;
    unique case (ocu_addr_e'(rd_addr))
      A_WLO: if (ptr_ok) rd_data = buf_q[ptr_q][DW-1:0];
      A_WHI: if (ptr_ok) rd_data = buf_q[ptr_q][TW-1:DW];
      A_PTR: rd_data = DW'(ptr_q);
      A_RLD: rd_data = DW'(rl_q);
      A_TEN: rd_data = DW'(te_q);
      A_LVL: rd_data = DW'(lvl_q);
      A_IEN: rd_data = DW'(ie_q);
      A_STS: rd_data = DW'(sts);
      default: rd_data = '0;
    endcase
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !uf) |=> act_flat == $past(act_flat));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !wr_rl) |=> rl_q == '0);
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] cnt,
  input  logic [TW-1:0] lat0,
  input  logic [TW-1:0] lat1,
  input  logic          te,
  input  logic          lvl,
  input  logic [1:0]    ie,
  input  logic          init,
  output logic          out,
  output logic [1:0]    irq
);
  logic hit0, hit1;
  logic out_q;
  logic [1:0] irq_q;

  assign hit0 = run && (cnt == lat0);
  assign hit1 = run && (cnt == lat1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      irq_q <= '0;
    end else begin
      irq_q <= {hit1 & ie[1], hit0 & ie[0]};
      if (init)
        out_q <= lvl;
      else if (te) begin
        if (hit1)      out_q <= lvl;
        else if (hit0) out_q <= ~lvl;
      end
    end
  end

  assign out = out_q;
  assign irq = irq_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !init) |=> out_q == $past(out_q));
  p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (te && !init && run && cnt == lat1) |=> out_q == $past(lvl));
  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == lat0 && ie[0]) |=> irq_q[0]);
endmodule

// File: rtl/ocu_top.sv
module ocu_top #(
  parameter int NCH = 3,
  parameter int TW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [TW/2-1:0]   wr_data,
  input  logic [2:0]        rd_addr,
  output logic [TW/2-1:0]   rd_data,
  input  logic              tmr_run,
  input  logic [TW-1:0]     tmr_reload,
  output logic [TW-1:0]     tmr_count,
  output logic              tmr_uf,
  output logic [NCH-1:0]    cmp_out,
  output logic [2*NCH-1:0]  cmp_irq
);
  localparam int NL = 2 * NCH;

  logic [TW-1:0]  cnt_w;
  logic           uf_w;
  logic [TW-1:0]  lat_w [NL];
  logic [NCH-1:0] te_w, lvl_w, init_w;
  logic [NL-1:0]  ie_w;

  ocu_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .reload(tmr_reload),
    .cnt(cnt_w), .uf(uf_w)
  );

  ocu_regs #(.NCH(NCH), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .run(tmr_run), .uf(uf_w), .sts(cmp_out), .lat_act(lat_w),
    .te(te_w), .lvl(lvl_w), .ie(ie_w), .init(init_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ocu_channel #(.TW(TW)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(tmr_run), .cnt(cnt_w),
      .lat0(lat_w[2*g]), .lat1(lat_w[2*g+1]),
      .te(te_w[g]), .lvl(lvl_w[g]), .ie(ie_w[2*g+1:2*g]),
      .init(init_w[g]), .out(cmp_out[g]), .irq(cmp_irq[2*g+1:2*g])
    );
  end

  assign tmr_count = cnt_w;
  assign tmr_uf    = uf_w;
endmodule

// File: tb/sim_ocu_top.sv
module sim_ocu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic run = 1'b0;
  logic [15:0] reload_v = 16'd7;
  logic [15:0] tmr_count;
  logic tmr_uf;
  logic [2:0] cmp_out;
  logic [5:0] cmp_irq;

  int checks = 0;
  int errors = 0;

  // reference state derived from the requirements
  logic [15:0] m_cnt;
  logic [15:0] m_buf [6];
  logic [15:0] m_act [6];
  logic [2:0]  m_ptr;
  logic [2:0]  m_rl, m_te, m_lvl, m_out;
  logic [5:0]  m_ie, m_irq;

  always #4 clk = ~clk;

  ocu_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_run(run), .tmr_reload(reload_v), .tmr_count(tmr_count),
    .tmr_uf(tmr_uf), .cmp_out(cmp_out), .cmp_irq(cmp_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_ptr = '0; m_rl = '0; m_te = '0; m_lvl = '0;
    m_out = '0; m_ie = '0; m_irq = '0;
    for (int i = 0; i < 6; i++) begin m_buf[i] = '0; m_act[i] = '0; end
  endtask

  task automatic model_step();
    logic [5:0] hit;
    logic [15:0] nbuf [6];
    bit ufv;
    ufv = run && (m_cnt == 0);
    for (int l = 0; l < 6; l++) hit[l] = run && (m_cnt == m_act[l]);
    for (int c = 0; c < 3; c++) begin
      if (wr_en && wr_addr == 3'd4 && wr_data[c] && !run) m_out[c] = m_lvl[c];
      else if (m_te[c]) begin
        if (hit[2*c+1]) m_out[c] = m_lvl[c];
        else if (hit[2*c]) m_out[c] = ~m_lvl[c];
      end
    end
    m_irq = hit & m_ie;
    for (int l = 0; l < 6; l++) begin
      nbuf[l] = m_buf[l];
      if (wr_en && m_ptr == 3'(l)) begin
        if (wr_addr == 3'd0) nbuf[l][7:0]  = wr_data;
        if (wr_addr == 3'd1) nbuf[l][15:8] = wr_data;
      end
    end
    for (int l = 0; l < 6; l++) begin
      if (!run && wr_en && wr_addr <= 3'd1 && m_ptr == 3'(l)) m_act[l] = nbuf[l];
      else if (ufv && m_rl[l/2]) m_act[l] = m_buf[l];
      m_buf[l] = nbuf[l];
    end
    m_rl = (ufv ? 3'b0 : m_rl) | ((wr_en && wr_addr == 3'd3) ? wr_data[2:0] : 3'b0);
    if (wr_en && wr_addr == 3'd2) m_ptr = wr_data[2:0];
    if (wr_en && wr_addr == 3'd4) m_te  = wr_data[2:0];
    if (wr_en && wr_addr == 3'd5) m_lvl = wr_data[2:0];
    if (wr_en && wr_addr == 3'd6) m_ie  = wr_data[5:0];
    if (run) m_cnt = (m_cnt == 0) ? reload_v : m_cnt - 16'd1;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 1'b0;
    chk(tmr_count == m_cnt, "R1", "count", tmr_count, m_cnt);
    chk(tmr_uf == (run && m_cnt == 0), "R1", "underflow", tmr_uf, run && m_cnt == 0);
    chk(cmp_out == m_out, tag, "output", cmp_out, m_out);
    chk(cmp_irq == m_irq, "R10", "irq", cmp_irq, m_irq);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(tag);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data == exp, tag, "readback", rd_data, exp);
  endtask

  task automatic do_reset();
    run = 1'b0; wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_latch(input int l, input logic [15:0] v, input string tag);
    wr(3'd2, 8'(l), tag);
    wr(3'd1, v[15:8], tag);
    wr(3'd0, v[7:0], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R12: reset state
    do_reset();
    chk(tmr_count == 0, "R12", "count after reset", tmr_count, 0);
    chk(cmp_out == 0, "R12", "out after reset", cmp_out, 0);
    chk(cmp_irq == 0, "R12", "irq after reset", cmp_irq, 0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R12");

    // R2: pointer width, window halves, invalid codes
    wr(3'd2, 8'hFF, "R2");
    rd_chk(3'd2, 8'h07, "R2");
    rd_chk(3'd0, 8'h00, "R2");
    wr(3'd2, 8'd3, "R2"); wr(3'd1, 8'h12, "R2"); wr(3'd0, 8'h34, "R2");
    wr(3'd2, 8'd2, "R2"); wr(3'd0, 8'h56, "R2"); wr(3'd1, 8'h78, "R2");
    wr(3'd2, 8'd3, "R2");
    rd_chk(3'd0, 8'h34, "R2"); rd_chk(3'd1, 8'h12, "R2");
    wr(3'd2, 8'd2, "R2");
    rd_chk(3'd0, 8'h56, "R2"); rd_chk(3'd1, 8'h78, "R2");
    wr(3'd2, 8'd6, "R2");
    rd_chk(3'd0, 8'h00, "R2"); rd_chk(3'd1, 8'h00, "R2");

    // R5 R6 R7: sweep channels and polarity, latches loaded while stopped
    for (int c = 0; c < 3; c++) begin
      for (int lv = 0; lv < 2; lv++) begin
        do_reset();
        reload_v = 16'd7;
        set_latch(2*c, 16'(1 + c), "R5");
        set_latch(2*c + 1, 16'd6, "R5");
        wr(3'd5, 8'(lv << c), "R7");
        wr(3'd6, 8'h3F, "R10");
        wr(3'd4, 8'(1 << c), "R6");
        chk(cmp_out[c] == 1'(lv), "R6", "init level", cmp_out[c], lv);
        run = 1'b1;
        repeat (20) tick("R7");
        run = 1'b0;
        tick("R13");
      end
    end

    // R8: trigger disabled, output holds, interrupts still fire
    do_reset();
    reload_v = 16'd7;
    set_latch(2, 16'd2, "R8"); set_latch(3, 16'd5, "R8");
    wr(3'd6, 8'h0C, "R8");
    run = 1'b1;
    repeat (16) tick("R8");
    chk(cmp_out == 3'b000, "R8", "held output", cmp_out, 0);

    // R9: equal latch values, x1 action wins
    do_reset();
    set_latch(0, 16'd3, "R9"); set_latch(1, 16'd3, "R9");
    wr(3'd5, 8'h01, "R9");
    wr(3'd4, 8'h01, "R9");
    run = 1'b1;
    repeat (12) tick("R9");
    chk(cmp_out[0] == 1'b1, "R9", "x1 priority level", cmp_out[0], 1);

    // R11: latch above reload never matches
    do_reset();
    reload_v = 16'd5;
    set_latch(4, 16'd9, "R11"); set_latch(5, 16'd2, "R11");
    wr(3'd6, 8'h3F, "R11");
    wr(3'd4, 8'h04, "R11");
    run = 1'b1;
    repeat (14) tick("R11");
    chk(cmp_out[2] == 1'b0, "R11", "fixed level", cmp_out[2], 0);

    // R3 R4: buffered update while running, committed at underflow
    do_reset();
    reload_v = 16'd7;
    set_latch(2, 16'd1, "R3"); set_latch(3, 16'd4, "R3");
    wr(3'd6, 8'h3F, "R3");
    wr(3'd4, 8'h02, "R3");
    run = 1'b1;
    repeat (10) tick("R3");
    set_latch(2, 16'd3, "R3"); set_latch(3, 16'd6, "R3");
    repeat (12) tick("R3");
    wr(3'd3, 8'h02, "R4");
    rd_chk(3'd3, 8'(m_rl), "R4");
    repeat (10) tick("R4");
    rd_chk(3'd3, 8'h00, "R4");
    repeat (10) tick("R4");

    // R13 R12: stopped timer holds, status readback
    run = 1'b0;
    repeat (5) tick("R13");
    rd_chk(3'd7, 8'(m_out), "R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule